// File: doc/BRIEF.md
# Interrupt Enable, Pending and Delegation Register Block

This block holds the machine-level interrupt enable, interrupt pending, interrupt delegation and exception delegation registers of a hart, together with the machine and supervisor trap-vector base registers. It also provides two supervisor-level windows, one for enable and one for pending. Each window shows and changes only the bit positions that the interrupt delegation register hands down. Software reaches every register through a simple word port: an address, write data and a write strobe. Read data comes back combinationally for the address presented.

Two hardware request lines feed the machine software and machine timer pending bits. A level hart interrupt request is raised whenever any pending bit is set and is dropped when every pending bit is clear. The bit positions follow the usual privileged interrupt layout: supervisor software 1, machine software 3, supervisor timer 5, machine timer 7, supervisor external 9, coprocessor 12. Choosing among interrupts and entering the trap is done by other logic.

Top module: `irq_deleg_csr`

## Requirements
- R1: After reset every register reads zero at all eight addresses (0 to 7) and the hart interrupt request is low while both request lines are low.
- R2: Interrupt delegation (address 2) keeps written values only in bits 1, 5, 9 and 12; all other bits read zero.
- R3: Machine enable (address 0) keeps written values only in bits 1, 3, 5, 7, 9 and 12; all other bits read zero.
- R4: Machine pending (address 1) accepts software writes only in bits 1 and 5. Bit 3 follows the software request line and bit 7 follows the timer request line, each one clock after the line changes. Every other bit reads zero.
- R5: Exception delegation (address 3) keeps written values in bits 0 to 13 and bit 15 only; bit 14 and all bits above 15 read zero.
- R6: The supervisor enable window (address 4) reads machine enable AND interrupt delegation. A write to it changes only the enable bits whose delegation bit is set.
- R7: The supervisor pending window (address 5) reads machine pending AND interrupt delegation. A write to it changes only the software-writable pending bits (1 and 5) whose delegation bit is set.
- R8: Machine vector (address 6) and supervisor vector (address 7) store the written value when write-data bits [1:0] are 00, with those bits stored as zero. Any other value in bits [1:0] leaves the register unchanged. The two vectors are independent.
- R9: The hart interrupt request is high exactly when machine pending is non-zero. It rises when pending leaves all-zero and falls when pending returns to all-zero.
- R10: Addresses 8 to 15 read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register word address |
| regWdata | input | XLEN | Write data |
| regWe | input | 1 | Write strobe, one write per cycle it is high |
| regRdata | output | XLEN | Read data for regAddr, combinational |
| softIrq | input | 1 | Machine software interrupt request line |
| timerIrq | input | 1 | Machine timer interrupt request line |
| hartIrq | output | 1 | Level hart interrupt request |

## Verification
Each machine register gets an all-ones write. This separates the writable bits from the fixed-zero bits, and it catches a mask that is one position off or that lets the reserved exception cause through. The supervisor windows are driven with the delegation register first holding a single bit and then holding the full set. Writing zeros and then all-ones through a window must move only the delegated positions, which shows whether a window is really masked or just aliases the machine register. The vector registers get one aligned value and two misaligned values with different mode bits, so a register that stores anyway, or one that clears the mode bits on a rejected write, gives a wrong read. The two request lines are raised alone, together, and then dropped, and the hart request is checked after each step.

// File: rtl/irq_deleg_pkg.sv
package irq_deleg_pkg;

  // Bit sets, indexed by interrupt or exception cause number
  localparam logic [15:0] DELEG_BITS  = 16'h1222; // sup soft/timer/ext + coprocessor
  localparam logic [15:0] ENABLE_BITS = 16'h12AA; // delegable + machine soft/timer
  localparam logic [15:0] SWPEND_BITS = 16'h0022; // software-writable pending
  localparam logic [15:0] EXC_BITS    = 16'hBFFF; // all causes but reserved 14

  localparam int BIT_MSOFT  = 3;
  localparam int BIT_MTIMER = 7;

  // Word addresses
  localparam int ADR_EN    = 0;
  localparam int ADR_PEND  = 1;
  localparam int ADR_DELEG = 2;
  localparam int ADR_EXC   = 3;
  localparam int ADR_SEN   = 4;
  localparam int ADR_SPEND = 5;
  localparam int ADR_MVEC  = 6;
  localparam int ADR_SVEC  = 7;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_EN, SEL_PEND, SEL_DELEG, SEL_EXC,
    SEL_SEN, SEL_SPEND, SEL_MVEC, SEL_SVEC
  } rd_sel_t;

  typedef struct packed {
    logic    wrEn;
    logic    wrPend;
    logic    wrDeleg;
    logic    wrExc;
    logic    wrSEn;
    logic    wrSPend;
    logic    wrMVec;
    logic    wrSVec;
    rd_sel_t rdSel;
  } csr_strobe_t;

endpackage

// File: rtl/irq_deleg_ctrl.sv
module irq_deleg_ctrl
  import irq_deleg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [1:0]        modeBits,
  output csr_strobe_t       stb
);

  logic modeDirect;
  assign modeDirect = (modeBits == 2'b00);

  always_comb begin
    stb = '0;
    stb.rdSel = SEL_NONE;
    if (regAddr == ADDR_W'(ADR_EN)) begin
      stb.rdSel = SEL_EN;
      stb.wrEn  = regWe;
    end else if (regAddr == ADDR_W'(ADR_PEND)) begin
      stb.rdSel  = SEL_PEND;
      stb.wrPend = regWe;
    end else if (regAddr == ADDR_W'(ADR_DELEG)) begin
      stb.rdSel   = SEL_DELEG;
      stb.wrDeleg = regWe;
    end else if (regAddr == ADDR_W'(ADR_EXC)) begin
      stb.rdSel = SEL_EXC;
      stb.wrExc = regWe;
    end else if (regAddr == ADDR_W'(ADR_SEN)) begin
      stb.rdSel = SEL_SEN;
      stb.wrSEn = regWe;
    end else if (regAddr == ADDR_W'(ADR_SPEND)) begin
      stb.rdSel   = SEL_SPEND;
      stb.wrSPend = regWe;
    end else if (regAddr == ADDR_W'(ADR_MVEC)) begin
      stb.rdSel  = SEL_MVEC;
      stb.wrMVec = regWe && modeDirect;
    end else if (regAddr == ADDR_W'(ADR_SVEC)) begin
      stb.rdSel  = SEL_SVEC;
      stb.wrSVec = regWe && modeDirect;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrEn, stb.wrPend, stb.wrDeleg, stb.wrExc,
              stb.wrSEn, stb.wrSPend, stb.wrMVec, stb.wrSVec})); // R10

  AST_VEC_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrMVec || stb.wrSVec) |-> (modeBits == 2'b00)); // R8

endmodule

// File: rtl/irq_deleg_dp.sv
module irq_deleg_dp
  import irq_deleg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  csr_strobe_t     stb,
  input  logic [XLEN-1:0] wdata,
  input  logic            softIrq,
  input  logic            timerIrq,
  output logic [XLEN-1:0] rdata,
  output logic            hartIrq
);

  localparam logic [XLEN-1:0] DelegM  = XLEN'(DELEG_BITS);
  localparam logic [XLEN-1:0] EnableM = XLEN'(ENABLE_BITS);
  localparam logic [XLEN-1:0] SwPendM = XLEN'(SWPEND_BITS);
  localparam logic [XLEN-1:0] ExcM    = XLEN'(EXC_BITS);
  localparam logic [XLEN-1:0] AlignM  = {{(XLEN-2){1'b1}}, 2'b00};

  logic [XLEN-1:0] enReg, pendReg, irqDeleg, excDeleg, machVec, supVec;
  logic [XLEN-1:0] enNext, pendNext, enWrMask, pendWrMask;

  // Which enable / pending bits a write may touch this cycle
  always_comb begin
    enWrMask   = '0;
    pendWrMask = '0;
    if (stb.wrEn)    enWrMask   = EnableM;
    if (stb.wrSEn)   enWrMask   = EnableM & irqDeleg;
    if (stb.wrPend)  pendWrMask = SwPendM;
    if (stb.wrSPend) pendWrMask = SwPendM & irqDeleg;
  end

  always_comb begin
    enNext   = (enReg & ~enWrMask) | (wdata & enWrMask);
    pendNext = (pendReg & ~pendWrMask) | (wdata & pendWrMask);
    pendNext[BIT_MSOFT]  = softIrq;
    pendNext[BIT_MTIMER] = timerIrq;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg    <= '0;
      pendReg  <= '0;
      irqDeleg <= '0;
      excDeleg <= '0;
      machVec  <= '0;
      supVec   <= '0;
    end else begin
      enReg   <= enNext;
      pendReg <= pendNext;
      if (stb.wrDeleg) irqDeleg <= wdata & DelegM;
      if (stb.wrExc)   excDeleg <= wdata & ExcM;
      if (stb.wrMVec)  machVec  <= wdata & AlignM;
      if (stb.wrSVec)  supVec   <= wdata & AlignM;
    end
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_EN:    rdata = enReg;
      SEL_PEND:  rdata = pendReg;
      SEL_DELEG: rdata = irqDeleg;
      SEL_EXC:   rdata = excDeleg;
      SEL_SEN:   rdata = enReg & irqDeleg;
      SEL_SPEND: rdata = pendReg & irqDeleg;
      SEL_MVEC:  rdata = machVec;
      SEL_SVEC:  rdata = supVec;
      default:   rdata = '0;
    endcase
  end

  assign hartIrq = |pendReg;

  AST_VEC_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    (machVec[1:0] == 2'b00) && (supVec[1:0] == 2'b00)); // R8

  AST_EXC_HOLE: assert property (@(posedge clk) disable iff (!rstN)
    excDeleg[14] == 1'b0); // R5

  AST_DELEG_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrDeleg |=> $stable(irqDeleg)); // R2

  AST_SEN_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSEn |=> ((enReg & ~$past(irqDeleg)) == ($past(enReg) & ~$past(irqDeleg)))); // R6

  AST_SPEND_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrSPend |=> ((pendReg & SwPendM & ~$past(irqDeleg)) ==
                     ($past(pendReg) & SwPendM & ~$past(irqDeleg)))); // R7

  AST_HART_RISE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hartIrq) |-> ($past(pendReg) == '0)); // R9

  AST_HART_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hartIrq) |-> (pendReg == '0)); // R9

endmodule

// File: rtl/irq_deleg_csr.sv
module irq_deleg_csr
  import irq_deleg_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [XLEN-1:0]   regWdata,
  input  logic              regWe,
  output logic [XLEN-1:0]   regRdata,
  input  logic              softIrq,
  input  logic              timerIrq,
  output logic              hartIrq
);

  csr_strobe_t stb;

  irq_deleg_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .regAddr  (regAddr),
    .regWe    (regWe),
    .modeBits (regWdata[1:0]),
    .stb      (stb)
  );

  irq_deleg_dp #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wdata    (regWdata),
    .softIrq  (softIrq),
    .timerIrq (timerIrq),
    .rdata    (regRdata),
    .hartIrq  (hartIrq)
  );

endmodule

// File: tb/irq_deleg_csr_tb.sv
`timescale 1ns/1ps
module irq_deleg_csr_tb;

  localparam int XLEN = 32;
  localparam int ADDR_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [XLEN-1:0] regWdata = '0;
  logic regWe = 1'b0;
  logic [XLEN-1:0] regRdata;
  logic softIrq = 1'b0;
  logic timerIrq = 1'b0;
  logic hartIrq;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_deleg_csr #(.XLEN(XLEN), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .softIrq(softIrq),
    .timerIrq(timerIrq), .hartIrq(hartIrq)
  );

  task automatic wr(input int a, input logic [XLEN-1:0] d);
    @(negedge clk);
    regAddr = ADDR_W'(a); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input int a, input logic [XLEN-1:0] exp, input string req);
    regAddr = ADDR_W'(a);
    #1;
    nTests++;
    if (regRdata !== exp) begin
      nFail++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, regRdata, exp);
    end
  endtask

  task automatic chkIrq(input logic exp, input string req);
    #1;
    nTests++;
    if (hartIrq !== exp) begin
      nFail++;
      $display("FAIL %s hartIrq: got %b expected %b", req, hartIrq, exp);
    end
  endtask

  task automatic tReset();
    for (int a = 0; a < 8; a++) rd(a, '0, "R1");
    chkIrq(1'b0, "R1");
  endtask

  task automatic tMachineMasks();
    wr(2, '1); rd(2, 32'h0000_1222, "R2");
    wr(0, '1); rd(0, 32'h0000_12AA, "R3");
    wr(3, '1); rd(3, 32'h0000_BFFF, "R5");
    wr(3, 32'h0000_4000); rd(3, 32'h0, "R5");
  endtask

  task automatic tPending();
    wr(1, '1); rd(1, 32'h0000_0022, "R4"); chkIrq(1'b1, "R9");
    wr(1, '0); rd(1, 32'h0, "R4"); chkIrq(1'b0, "R9");
    @(negedge clk); softIrq = 1'b1;
    @(negedge clk); rd(1, 32'h0000_0008, "R4"); chkIrq(1'b1, "R9");
    timerIrq = 1'b1;
    @(negedge clk); rd(1, 32'h0000_0088, "R4");
    wr(1, '0); rd(1, 32'h0000_0088, "R4");
    softIrq = 1'b0; timerIrq = 1'b0;
    @(negedge clk); rd(1, 32'h0, "R4"); chkIrq(1'b0, "R9");
  endtask

  task automatic tSupEnable();
    wr(2, 32'h0000_0020);
    rd(4, 32'h0000_0020, "R6");
    wr(4, '0); rd(0, 32'h0000_128A, "R6"); rd(4, 32'h0, "R6");
    wr(4, '1); rd(0, 32'h0000_12AA, "R6");
  endtask

  task automatic tSupPending();
    wr(2, 32'h0000_0020);
    wr(5, '1); rd(1, 32'h0000_0020, "R7"); rd(5, 32'h0000_0020, "R7");
    wr(2, 32'h0000_1222);
    wr(5, 32'h0000_0002); rd(1, 32'h0000_0002, "R7"); rd(5, 32'h0000_0002, "R7");
    wr(1, '0); rd(5, 32'h0, "R7");
  endtask

  task automatic tVectors();
    wr(6, 32'h8000_1000); rd(6, 32'h8000_1000, "R8");
    wr(6, 32'h0000_1235); rd(6, 32'h8000_1000, "R8");
    wr(6, 32'h0000_4002); rd(6, 32'h8000_1000, "R8");
    wr(7, 32'h2000_0100); rd(7, 32'h2000_0100, "R8");
    wr(7, 32'hFFFF_FFFF); rd(7, 32'h2000_0100, "R8");
    rd(6, 32'h8000_1000, "R8");
  endtask

  task automatic tUnmapped();
    wr(9, '1);  rd(9, '0, "R10");
    wr(15, '1); rd(15, '0, "R10");
    rd(2, 32'h0000_1222, "R10"); rd(0, 32'h0000_12AA, "R10");
    rd(1, 32'h0, "R10"); rd(6, 32'h8000_1000, "R10");
  endtask

  initial begin
    #12;
    @(negedge clk); rstN = 1'b1;
    tReset();
    tMachineMasks();
    tPending();
    tSupEnable();
    tSupPending();
    tVectors();
    tUnmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule